// File: doc/BRIEF.md
# Sub-Register Access General-Purpose Register File

This block holds sixteen 64-bit general-purpose registers and lets an execution pipeline read and write them at byte, word, doubleword or full width. Each access names a register with a 3-bit field taken from the instruction. It also carries a flag that says whether the register-extension prefix was present, the extension bit that prefix supplies, and a 2-bit operand size code. The block resolves these into a physical register and a bit slice.

There are two independent read ports and one write port. Reads are combinational from the stored state and return the selected slice right-aligned and zero-extended to 64 bits. A write merges its slice into the stored register on the rising clock edge, so a read in the next cycle sees it.

Byte access is the unusual part. Without the prefix, numbers 4 to 7 reach bits 15:8 of the first four registers. With the prefix, every number reaches the low byte of its own register, and registers 8 to 15 have no high-byte form at all.

Top module: `gpr_slice_file`

## Requirements
- R1: For 16-, 32- and 64-bit accesses, the register is {ext, field} when the prefix flag is 1. When the flag is 0 the register is the field alone and the extension bit is ignored.
- R2: For byte accesses (size code 0) without the prefix, numbers 0 to 3 select bits 7:0 of registers 0 to 3. Numbers 4 to 7 select bits 15:8 of registers 0 to 3.
- R3: For byte accesses with the prefix, number {ext, field} selects bits 7:0 of that register, for all sixteen registers. This includes numbers 4 to 7 and 8 to 15.
- R4: Size codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. Read data is the selected slice shifted down to bit 0, with all higher bits zero.
- R5: A byte write (low or high byte) or a 16-bit write leaves every other bit of the target register unchanged.
- R6: A 32-bit write stores its low 32 bits and clears bits 63:32 of the target. A 64-bit write replaces the whole register.
- R7: A write with the write enable high takes effect at the rising edge and is visible to reads in the next cycle. With the enable low, no register changes.
- R8: A synchronous reset clears all sixteen registers to zero.
- R9: The two read ports decode and return data independently of each other and of the write port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd0_fld | input | 3 | Read port 0 register field |
| rd0_pfx | input | 1 | Read port 0 extension prefix present |
| rd0_ext | input | 1 | Read port 0 extension bit (register number MSB) |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 64 | Read port 0 zero-extended slice |
| rd1_fld | input | 3 | Read port 1 register field |
| rd1_pfx | input | 1 | Read port 1 extension prefix present |
| rd1_ext | input | 1 | Read port 1 extension bit |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 64 | Read port 1 zero-extended slice |
| wr_en | input | 1 | Write enable |
| wr_fld | input | 3 | Write register field |
| wr_pfx | input | 1 | Write extension prefix present |
| wr_ext | input | 1 | Write extension bit |
| wr_size | input | 2 | Write size code |
| wr_data | input | 64 | Write data, slice taken from the low bits |

## Verification
The assertions check the following on every cycle:
- zero extension of byte reads;
- the high-byte and prefixed-byte read decodes against the stored registers;
- preservation of the untouched bits on 16-bit writes;
- clearing of the upper half on 32-bit writes;
- that state holds when the enable is low;
- the reset clear.

Only the bench scenarios show the rest:
- that the extension bit is ignored without the prefix;
- that a high-byte write lands in bits 15:8 of the right register;
- that numbers 8 to 15 never reach a high byte;
- that both read ports agree with a behavioural model through long mixed sequences of writes of all widths.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int FLD_W = 3;
    localparam int IDX_W = FLD_W + 1;
    localparam int NREG  = 1 << IDX_W;
    localparam int NRD   = 2;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_D = 2'd2,
        SZ_Q = 2'd3
    } opsz_e;
endpackage

// File: rtl/gpr_locate.sv
// Resolves field/prefix/extension/size into a physical index and a high-byte flag.
module gpr_locate
    import gpr_pkg::*;
(
    input  logic [FLD_W-1:0] fld,
    input  logic             pfx,
    input  logic             ext,
    input  logic [1:0]       size,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);
    always_comb begin
        hi  = 1'b0;
        idx = pfx ? {ext, fld} : {1'b0, fld};
        if (size == SZ_B && !pfx && fld[FLD_W-1]) begin
            // legacy byte numbering: upper half of the field picks bits 15:8
            hi  = 1'b1;
            idx = {{(IDX_W-FLD_W+1){1'b0}}, fld[FLD_W-2:0]};
        end
    end
endmodule

// File: rtl/gpr_rd_slice.sv
// Extracts the selected slice and right-aligns it, zero-extended.
module gpr_rd_slice
    import gpr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] word,
    input  logic [1:0]      size,
    input  logic            hi,
    output logic [XLEN-1:0] data
);
    localparam int HALF = XLEN / 2;

    always_comb begin
        data = '0;
        case (size)
            SZ_B:    data[7:0] = hi ? word[15:8] : word[7:0];
            SZ_W:    data[15:0] = word[15:0];
            SZ_D:    data[HALF-1:0] = word[HALF-1:0];
            default: data = word;
        endcase
    end
endmodule

// File: rtl/gpr_wr_merge.sv
// Merges write data into the old register value according to size.
module gpr_wr_merge
    import gpr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] old,
    input  logic [XLEN-1:0] wd,
    input  logic [1:0]      size,
    input  logic            hi,
    output logic [XLEN-1:0] merged
);
    localparam int HALF = XLEN / 2;

    always_comb begin
        merged = old;
        case (size)
            SZ_B: begin
                if (hi) merged[15:8] = wd[7:0];
                else    merged[7:0]  = wd[7:0];
            end
            SZ_W: merged[15:0] = wd[15:0];
            SZ_D: begin
                merged = '0;
                merged[HALF-1:0] = wd[HALF-1:0];
            end
            default: merged = wd;
        endcase
    end
endmodule

// File: rtl/gpr_slice_file.sv
module gpr_slice_file
    import gpr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       rd0_fld,
    input  logic             rd0_pfx,
    input  logic             rd0_ext,
    input  logic [1:0]       rd0_size,
    output logic [XLEN-1:0]  rd0_data,
    input  logic [2:0]       rd1_fld,
    input  logic             rd1_pfx,
    input  logic             rd1_ext,
    input  logic [1:0]       rd1_size,
    output logic [XLEN-1:0]  rd1_data,
    input  logic             wr_en,
    input  logic [2:0]       wr_fld,
    input  logic             wr_pfx,
    input  logic             wr_ext,
    input  logic [1:0]       wr_size,
    input  logic [XLEN-1:0]  wr_data
);
    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] gpr;
    } gpr_state_t;

    gpr_state_t state_d, state_q;
    logic [NREG-1:0][XLEN-1:0] gpr_q;
    assign gpr_q = state_q.gpr;

    // ---------------- write path ----------------
    logic [IDX_W-1:0] wr_idx;
    logic             wr_hi;
    logic [XLEN-1:0]  wr_merged;

    gpr_locate u_wr_loc (
        .fld (wr_fld),
        .pfx (wr_pfx),
        .ext (wr_ext),
        .size(wr_size),
        .idx (wr_idx),
        .hi  (wr_hi)
    );

    gpr_wr_merge #(.XLEN(XLEN)) u_wr_merge (
        .old   (gpr_q[wr_idx]),
        .wd    (wr_data),
        .size  (wr_size),
        .hi    (wr_hi),
        .merged(wr_merged)
    );

    // ---------------- read ports ----------------
    logic [FLD_W-1:0] rp_fld  [NRD];
    logic             rp_pfx  [NRD];
    logic             rp_ext  [NRD];
    logic [1:0]       rp_size [NRD];
    logic [XLEN-1:0]  rp_data [NRD];

    assign rp_fld[0]  = rd0_fld;
    assign rp_pfx[0]  = rd0_pfx;
    assign rp_ext[0]  = rd0_ext;
    assign rp_size[0] = rd0_size;
    assign rp_fld[1]  = rd1_fld;
    assign rp_pfx[1]  = rd1_pfx;
    assign rp_ext[1]  = rd1_ext;
    assign rp_size[1] = rd1_size;

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic [IDX_W-1:0] idx;
        logic             hi;

        gpr_locate u_loc (
            .fld (rp_fld[g]),
            .pfx (rp_pfx[g]),
            .ext (rp_ext[g]),
            .size(rp_size[g]),
            .idx (idx),
            .hi  (hi)
        );

        gpr_rd_slice #(.XLEN(XLEN)) u_slice (
            .word(gpr_q[idx]),
            .size(rp_size[g]),
            .hi  (hi),
            .data(rp_data[g])
        );
    end

    assign rd0_data = rp_data[0];
    assign rd1_data = rp_data[1];

    // ---------------- state update ----------------
    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d = '0;
        end else if (wr_en) begin
            state_d.gpr[wr_idx] = wr_merged;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end
endmodule

// File: rtl/gpr_slice_file_chk.sv
module gpr_slice_file_chk
    import gpr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NREG-1:0][XLEN-1:0] gpr_q,
    input logic                      wr_en,
    input logic [1:0]                wr_size,
    input logic [IDX_W-1:0]          wr_idx,
    input logic [2:0]                rd0_fld,
    input logic                      rd0_pfx,
    input logic                      rd0_ext,
    input logic [1:0]                rd0_size,
    input logic [XLEN-1:0]           rd0_data,
    input logic [1:0]                rd1_size,
    input logic [XLEN-1:0]           rd1_data
);
    localparam int HALF = XLEN / 2;

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> gpr_q == '0);

    assert_high_byte_read_R2: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == SZ_B && !rd0_pfx && rd0_fld[2])
        |-> rd0_data == {{(XLEN-8){1'b0}}, gpr_q[{2'b00, rd0_fld[1:0]}][15:8]});

    assert_prefixed_byte_read_R3: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == SZ_B && rd0_pfx)
        |-> rd0_data == {{(XLEN-8){1'b0}}, gpr_q[{rd0_ext, rd0_fld}][7:0]});

    assert_byte_zero_ext_R4: assert property (@(posedge clk) disable iff (rst)
        (rd1_size == SZ_B) |-> rd1_data[XLEN-1:8] == '0);

    assert_word_write_keeps_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == SZ_W)
        |=> gpr_q[$past(wr_idx)][XLEN-1:16] == $past(gpr_q[wr_idx][XLEN-1:16]));

    assert_dword_write_clears_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == SZ_D) |=> gpr_q[$past(wr_idx)][XLEN-1:HALF] == '0);

    assert_idle_holds_state_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(gpr_q));
endmodule

bind gpr_slice_file gpr_slice_file_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .gpr_q   (gpr_q),
    .wr_en   (wr_en),
    .wr_size (wr_size),
    .wr_idx  (wr_idx),
    .rd0_fld (rd0_fld),
    .rd0_pfx (rd0_pfx),
    .rd0_ext (rd0_ext),
    .rd0_size(rd0_size),
    .rd0_data(rd0_data),
    .rd1_size(rd1_size),
    .rd1_data(rd1_data)
);

// File: tb/gpr_slice_file_tb.sv
`timescale 1ns/1ps
module gpr_slice_file_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  rd0_fld, rd1_fld, wr_fld;
    logic        rd0_pfx, rd1_pfx, wr_pfx;
    logic        rd0_ext, rd1_ext, wr_ext;
    logic [1:0]  rd0_size, rd1_size, wr_size;
    logic [63:0] rd0_data, rd1_data, wr_data;
    logic        wr_en;

    int errors = 0;
    int checks = 0;
    logic [63:0] model [16];

    always #2.5 clk = ~clk;

    gpr_slice_file u_dut (.*);

    // behavioural reference
    function automatic int tgt(input logic [2:0] f, input logic p, input logic e, input logic [1:0] s);
        if (s == 2'd0 && !p && f >= 3'd4) return int'(f) - 4;
        return p ? int'({e, f}) : int'(f);
    endfunction

    function automatic bit is_hi(input logic [2:0] f, input logic p, input logic [1:0] s);
        return (s == 2'd0 && !p && f >= 3'd4);
    endfunction

    function automatic logic [63:0] exp_rd(input logic [2:0] f, input logic p, input logic e, input logic [1:0] s);
        logic [63:0] r;
        r = model[tgt(f, p, e, s)];
        case (s)
            2'd0: return is_hi(f, p, s) ? {56'd0, r[15:8]} : {56'd0, r[7:0]};
            2'd1: return {48'd0, r[15:0]};
            2'd2: return {32'd0, r[31:0]};
            default: return r;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] f, input logic p, input logic [1:0] s);
        if (is_hi(f, p, s)) return "R2";
        if (s == 2'd0 && p) return "R3";
        if (s == 2'd0) return "R4";
        return "R1";
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write();
        int i;
        i = tgt(wr_fld, wr_pfx, wr_ext, wr_size);
        case (wr_size)
            2'd0: if (is_hi(wr_fld, wr_pfx, wr_size)) model[i][15:8] = wr_data[7:0];
                  else model[i][7:0] = wr_data[7:0];
            2'd1: model[i][15:0] = wr_data[15:0];
            2'd2: model[i] = {32'd0, wr_data[31:0]};
            default: model[i] = wr_data;
        endcase
    endtask

    // one cycle: inputs already driven after a negedge; compare reads, clock, update model
    task automatic step();
        #1;
        check(tag_of(rd0_fld, rd0_pfx, rd0_size), rd0_data, exp_rd(rd0_fld, rd0_pfx, rd0_ext, rd0_size));
        check("R9", rd1_data, exp_rd(rd1_fld, rd1_pfx, rd1_ext, rd1_size));
        @(posedge clk);
        if (wr_en) model_write();
        @(negedge clk);
    endtask

    task automatic set_rd0(input logic [2:0] f, input logic p, input logic e, input logic [1:0] s);
        rd0_fld = f; rd0_pfx = p; rd0_ext = e; rd0_size = s;
    endtask

    task automatic do_wr(input logic [2:0] f, input logic p, input logic e, input logic [1:0] s, input logic [63:0] d);
        wr_en = 1'b1; wr_fld = f; wr_pfx = p; wr_ext = e; wr_size = s; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] f, input logic p, input logic e, input logic [1:0] s, input logic [63:0] exp);
        set_rd0(f, p, e, s);
        #1;
        check(tag, rd0_data, exp);
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0;
        wr_fld = '0; wr_pfx = 0; wr_ext = 0; wr_size = 2'd3; wr_data = '0;
        set_rd0(3'd0, 1'b0, 1'b0, 2'd3);
        rd1_fld = '0; rd1_pfx = 0; rd1_ext = 0; rd1_size = 2'd3;
        foreach (model[i]) model[i] = '0;
        // dirty the registers before reset
        repeat (2) @(negedge clk);
        rst = 1'b0;
        do_wr(3'd3, 1'b1, 1'b1, 2'd3, 64'hDEAD_BEEF_0000_1111);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        foreach (model[i]) model[i] = '0;
        // R8: every register reads zero after reset
        for (int r = 0; r < 16; r++) begin
            rd_chk("R8", 3'(r), 1'b1, r[3], 2'd3, 64'd0);
        end

        // R6: 64-bit write to reg 0, then 32-bit write to reg 9 clears its upper half
        do_wr(3'd0, 1'b0, 1'b0, 2'd3, 64'h1122_3344_5566_A7B8);
        do_wr(3'd1, 1'b1, 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        do_wr(3'd1, 1'b1, 1'b1, 2'd2, 64'h0123_4567_89AB_CDEF);
        rd_chk("R6", 3'd1, 1'b1, 1'b1, 2'd3, 64'h0000_0000_89AB_CDEF);
        // R7: value written last cycle is visible
        rd_chk("R7", 3'd0, 1'b0, 1'b0, 2'd3, 64'h1122_3344_5566_A7B8);
        // R2: number 4 without prefix = bits 15:8 of reg 0
        rd_chk("R2", 3'd4, 1'b0, 1'b0, 2'd0, 64'h0000_0000_0000_00A7);
        // R1: ext ignored without prefix (reads reg 0, not reg 8)
        rd_chk("R1", 3'd0, 1'b0, 1'b1, 2'd3, 64'h1122_3344_5566_A7B8);
        // R5: high-byte write via number 4 (reg 0 bits 15:8)
        do_wr(3'd4, 1'b0, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FF3C);
        rd_chk("R5", 3'd0, 1'b0, 1'b0, 2'd3, 64'h1122_3344_5566_3CB8);
        // R3: prefixed byte write number 4 targets reg 4 low byte, reg 0 untouched
        do_wr(3'd4, 1'b1, 1'b0, 2'd0, 64'h0000_0000_0000_0077);
        rd_chk("R3", 3'd4, 1'b1, 1'b0, 2'd3, 64'h0000_0000_0000_0077);
        rd_chk("R3", 3'd0, 1'b0, 1'b0, 2'd3, 64'h1122_3344_5566_3CB8);
        // R3: reg 9 byte access only reaches bits 7:0
        rd_chk("R3", 3'd1, 1'b1, 1'b1, 2'd0, 64'h0000_0000_0000_00EF);
        // R5: 16-bit write to reg 9 keeps upper bits
        do_wr(3'd1, 1'b1, 1'b1, 2'd1, 64'hAAAA_AAAA_AAAA_5A5A);
        rd_chk("R5", 3'd1, 1'b1, 1'b1, 2'd3, 64'h0000_0000_89AB_5A5A);
        // R4: 16-bit read zero-extends
        rd_chk("R4", 3'd0, 1'b0, 1'b0, 2'd1, 64'h0000_0000_0000_3CB8);
        // R7: enable low, data presented, nothing changes
        wr_fld = 3'd0; wr_pfx = 1'b0; wr_size = 2'd3; wr_data = '1;
        set_rd0(3'd0, 1'b0, 1'b0, 2'd3);
        step();
        rd_chk("R7", 3'd0, 1'b0, 1'b0, 2'd3, 64'h1122_3344_5566_3CB8);

        // mixed random traffic compared to the model every cycle
        for (int n = 0; n < 3000; n++) begin
            wr_en   = ($urandom % 4) != 0;
            wr_fld  = 3'($urandom); wr_pfx = 1'($urandom); wr_ext = 1'($urandom);
            wr_size = 2'($urandom);
            wr_data = {$urandom, $urandom};
            set_rd0(3'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
            rd1_fld = 3'($urandom); rd1_pfx = 1'($urandom); rd1_ext = 1'($urandom);
            rd1_size = 2'($urandom);
            step();
        end
        wr_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule